// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the command front end of a serial flash slave for programming in auto-increment word mode. It takes the serial input bits, already sampled into the system clock domain as one strobe per SCK rising edge, together with the chip-select level. It assembles them into bytes with the most significant bit first. When chip select is released on a byte boundary, it decides what the frame meant. The first auto-increment frame carries an opcode, a 24-bit address and two data bytes. Each later frame carries only the opcode and two data bytes, and is written to the next word.

Each accepted word becomes a one-cycle request to a self-timed program engine. The engine is modelled here as a counter that stays busy for `PROG_CYCLES` clock cycles. While the sequence runs, only the continuation opcode, status read and write-disable are honoured. After the word that reaches the highest unprotected address, given on `top_addr`, the block leaves the mode by itself and drops write enable. Optionally, the serial output pin reports ready/busy while chip select is low during the sequence.

Top module: `aai_prog_seq`

## Requirements
- R1: After reset, `aai_active`, `wel`, `busy`, `prog_req` and `so_oe` are 0.
- R2: A one-byte frame 06h sets `wel` when the mode is not active. A one-byte frame 04h clears both `wel` and `aai_active`.
- R3: Suppose `wel` is 1, the engine is idle and the mode is inactive. A six-byte frame AD, A[23:16], A[15:8], A[7:0], D0, D1 then issues `prog_req` with `prog_addr` = A with bit 0 cleared and `prog_data` = {D0, D1}, and sets `aai_active`. D0 is the byte for the even address and sits in `prog_data[15:8]`.
- R4: While the mode is active, a three-byte frame AD, D0, D1 programs the word at the previous `prog_addr` + 2.
- R5: While the mode is active, one-byte frames other than 04h have no effect on the outputs, and neither does any frame whose opcode is not ADh.
- R6: A frame acts only when chip select rises after a whole number of bytes. A partial byte, or a byte count other than the one its opcode needs, discards the frame.
- R7: `busy` stays high for `PROG_CYCLES` cycles after each `prog_req`. A continuation frame that ends while `busy` is high is ignored.
- R8: A start frame is ignored if `wel` is 0 or if the odd byte of the target word lies above `top_addr`.
- R9: When the programmed word's odd address + 2 exceeds `top_addr`, `aai_active` and `wel` clear with the request.
- R10: One-byte frames 70h and 80h, outside the mode, enable and disable ready/busy output. When it is enabled, the mode is active and chip select is low, `so_oe` is 1 and `so_rb` is 1 for ready and 0 for busy. Otherwise `so_oe` is 0.
- R11: Bytes are assembled most significant bit first: the byte 60h is not taken as 06h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select level, active low, synchronised |
| bit_valid | input | 1 | One-cycle strobe per sampled SCK rising edge |
| bit_in | input | 1 | Serial input bit for the strobe |
| top_addr | input | AW | Highest unprotected byte address |
| prog_req | output | 1 | One-cycle word program request |
| prog_addr | output | AW | Even byte address of the word |
| prog_data | output | 16 | Even byte in [15:8], odd byte in [7:0] |
| busy | output | 1 | Program engine busy |
| wel | output | 1 | Write enable latch |
| aai_active | output | 1 | Auto-increment mode active |
| so_oe | output | 1 | Serial output driven with ready/busy |
| so_rb | output | 1 | Ready/busy value, 1 = ready |

## Verification
Continuation words carry random data and are mixed with random opcodes, drawn from a pool of values the mode must refuse. This separates a sequencer that tracks the address in its own state from one that takes an address from the frame, or one that lets stray commands disturb it. Directed frames cover the cases that a correct and a slightly broken frame decoder handle differently: a frame cut mid-byte, a frame one byte short, a frame sent while busy, and a frame with the byte order reversed. A start just past the protection limit and a run ending exactly on it test the two sides of the range comparison. The ready/busy pin is checked both busy and ready, and again after it has been disabled.

// File: rtl/aai_prog_seq.sv
module aai_prog_seq #(
  parameter int AW          = 24,
  parameter int PROG_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          bit_valid,
  input  logic          bit_in,
  input  logic [AW-1:0] top_addr,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [15:0]   prog_data,
  output logic          busy,
  output logic          wel,
  output logic          aai_active,
  output logic          so_oe,
  output logic          so_rb
);
  localparam int ABYTES    = (AW + 7) / 8;
  localparam int FIRST_LEN = 1 + ABYTES + 2;
  localparam int FW        = 8 * FIRST_LEN;
  localparam int CW        = $clog2(PROG_CYCLES + 1);

  logic          cs_q, rb_en;
  logic [2:0]    bcnt;
  logic [3:0]    nbytes;
  logic [7:0]    sh;
  logic [FW-1:0] frm;
  logic [CW-1:0] cnt;
  logic [AW-1:0] cur;

  function automatic logic in_range(input logic [AW-1:0] b);
    return ({1'b0, b} | (AW+1)'(1)) <= {1'b0, top_addr};
  endfunction

  function automatic logic is_last(input logic [AW-1:0] b);
    return ({1'b0, b} + (AW+1)'(3)) > {1'b0, top_addr};
  endfunction

  wire          rise     = cs_n & ~cs_q;
  wire          whole    = rise & (bcnt == 3'd0);
  wire [7:0]    op1      = frm[7:0];
  wire [7:0]    op3      = frm[23:16];
  wire [7:0]    opf      = frm[FW-1 -: 8];
  wire [AW-1:0] a_in     = frm[16 +: AW];
  wire [AW-1:0] b_first  = {a_in[AW-1:1], 1'b0};
  wire [AW-1:0] b_next   = cur + AW'(2);
  wire          one_byte = whole & (nbytes == 4'd1);

  wire start_first = whole & ~aai_active & wel & ~busy & (nbytes == 4'(FIRST_LEN))
                     & (opf == 8'hAD) & in_range(b_first);
  wire start_next  = whole & aai_active & ~busy & (nbytes == 4'd3)
                     & (op3 == 8'hAD) & in_range(b_next);
  wire [AW-1:0] base = aai_active ? b_next : b_first;

  wire c_wren = one_byte & ~aai_active & (op1 == 8'h06);
  wire c_wrdi = one_byte & (op1 == 8'h04);
  wire c_ebsy = one_byte & ~aai_active & (op1 == 8'h70);
  wire c_dbsy = one_byte & ~aai_active & (op1 == 8'h80);

  assign busy  = (cnt != '0);
  assign so_oe = ~cs_n & rb_en & aai_active;
  assign so_rb = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1; rb_en <= 1'b0; bcnt <= '0; nbytes <= '0; sh <= '0;
      frm <= '0; cnt <= '0; cur <= '0; prog_req <= 1'b0;
      prog_addr <= '0; prog_data <= '0; wel <= 1'b0; aai_active <= 1'b0;
    end else begin
      cs_q     <= cs_n;
      prog_req <= 1'b0;
      if (cs_n) begin
        bcnt   <= '0;
        nbytes <= '0;
      end else if (bit_valid) begin
        sh   <= {sh[6:0], bit_in};
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          frm    <= {frm[FW-9:0], sh[6:0], bit_in};
          nbytes <= (nbytes == 4'hF) ? nbytes : nbytes + 4'd1;
        end
      end
      if (busy) cnt <= cnt - CW'(1);
      if (c_wren) wel <= 1'b1;
      if (c_wrdi) begin
        wel        <= 1'b0;
        aai_active <= 1'b0;
      end
      if (c_ebsy) rb_en <= 1'b1;
      if (c_dbsy) rb_en <= 1'b0;
      if (start_first | start_next) begin
        prog_req  <= 1'b1;
        prog_addr <= base;
        prog_data <= frm[15:0];
        cur       <= base;
        cnt       <= CW'(PROG_CYCLES);
        if (is_last(base)) begin
          aai_active <= 1'b0;
          wel        <= 1'b0;
        end else begin
          aai_active <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aai_prog_seq_chk.sv
module aai_prog_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic [AW-1:0] top_addr,
  input logic          prog_req,
  input logic [AW-1:0] prog_addr,
  input logic          busy,
  input logic          wel,
  input logic          aai_active,
  input logic          so_oe
);
  a_r3_even_word: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (prog_addr[0] == 1'b0));

  a_r6_commit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(cs_n));

  a_r7_busy_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> busy);

  a_r7_no_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !$past(busy));

  a_r9_exit_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && (({1'b0, prog_addr} + (AW+1)'(3)) > {1'b0, top_addr}))
      |-> (!aai_active && !wel));

  a_r2_mode_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    aai_active |-> wel);

  a_r10_so_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (!cs_n && aai_active));
endmodule

bind aai_prog_seq aai_prog_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .top_addr(top_addr),
  .prog_req(prog_req), .prog_addr(prog_addr), .busy(busy), .wel(wel),
  .aai_active(aai_active), .so_oe(so_oe)
);

// File: tb/aai_prog_seq_tb_top.sv
module aai_prog_seq_tb_top;
  localparam int AW = 24;
  localparam int PC = 64;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, bit_valid = 1'b0, bit_in = 1'b0;
  logic [AW-1:0] top_addr = 24'h00FFFF;
  logic prog_req, busy, wel, aai_active, so_oe, so_rb;
  logic [AW-1:0] prog_addr;
  logic [15:0] prog_data;
  int checks = 0, errors = 0;
  logic [AW-1:0] exp_addr;

  always #2.5 clk = ~clk;

  aai_prog_seq #(.AW(AW), .PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .top_addr(top_addr), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .busy(busy), .wel(wel), .aai_active(aai_active),
    .so_oe(so_oe), .so_rb(so_rb));

  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + 24'd2;
  endfunction

  function automatic logic exp_exit(input logic [AW-1:0] a, input logic [AW-1:0] t);
    return ({1'b0, a} + 25'd3) > {1'b0, t};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [63:0] v, input int nb, input int extra);
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nb * 8 + extra; i++) begin
      bit_in = v[63 - i];
      bit_valid = 1'b1;
      @(negedge clk);
    end
    bit_valid = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [7:0] bad_ops [6];
    bad_ops = '{8'h06, 8'h70, 8'h02, 8'h20, 8'hC7, 8'h9F};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 aai", aai_active, 0); chk("R1 wel", wel, 0); chk("R1 busy", busy, 0);
    chk("R1 req", prog_req, 0); chk("R1 so_oe", so_oe, 0);

    frame({8'hAD, 24'h001234, 16'hA55A, 16'h0}, 6, 0);
    chk("R8 no wel req", prog_req, 0); chk("R8 no wel aai", aai_active, 0);

    frame({8'h60, 56'h0}, 1, 0);
    chk("R11 60h not wren", wel, 0);
    frame({8'h06, 56'h0}, 1, 0);
    chk("R2 wren", wel, 1);

    frame({8'hAD, 24'h001234, 16'hA5, 16'h0}, 5, 0);
    chk("R6 short start", prog_req, 0);
    frame({8'hAD, 24'h001235, 16'hC3E1, 16'h0}, 6, 0);
    chk("R3 req", prog_req, 1); chk("R3 addr", prog_addr, 24'h001234);
    chk("R3 data", prog_data, 16'hC3E1); chk("R3 aai", aai_active, 1);
    exp_addr = 24'h001234;

    chk("R7 busy", busy, 1);
    frame({8'hAD, 16'h1111, 40'h0}, 3, 0);
    chk("R7 ignored while busy", prog_req, 0);
    wait_idle();

    frame({8'hAD, 16'h2222, 40'h0}, 3, 3);
    chk("R6 partial byte", prog_req, 0);
    frame({8'hAD, 16'h2222, 8'h33, 32'h0}, 4, 0);
    chk("R6 wrong count", prog_req, 0);
    frame({8'h05, 56'h0}, 1, 0);
    chk("R5 rdsr keeps mode", aai_active, 1);

    for (int k = 0; k < 12; k++) begin
      if ($urandom_range(0, 1) == 1) begin
        frame({bad_ops[$urandom_range(0, 5)], 56'h0}, 1, 0);
        chk("R5 illegal req", prog_req, 0); chk("R5 illegal aai", aai_active, 1);
        chk("R5 illegal wel", wel, 1);
      end
      d = 16'($urandom);
      frame({8'hAD, d, 40'h0}, 3, 0);
      exp_addr = next_word(exp_addr);
      chk("R4 req", prog_req, 1); chk("R4 addr", prog_addr, exp_addr);
      chk("R4 data", prog_data, d);
      wait_idle();
    end
    frame({8'h02, 16'h7777, 40'h0}, 3, 0);
    chk("R5 non-AD frame", prog_req, 0);

    frame({8'h04, 56'h0}, 1, 0);
    chk("R2 wrdi aai", aai_active, 0); chk("R2 wrdi wel", wel, 0);

    top_addr = 24'h002007;
    frame({8'h06, 56'h0}, 1, 0);
    frame({8'hAD, 24'h002008, 16'hBEEF, 16'h0}, 6, 0);
    chk("R8 protected", prog_req, 0); chk("R8 protected aai", aai_active, 0);

    frame({8'h70, 56'h0}, 1, 0);
    frame({8'hAD, 24'h002002, 16'h0102, 16'h0}, 6, 0);
    chk("R3 second start", prog_addr, 24'h002002);
    exp_addr = 24'h002002;
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    chk("R10 so_oe busy", so_oe, 1); chk("R10 so_rb busy", so_rb, 0);
    wait_idle();
    chk("R10 so_rb ready", so_rb, 1);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R10 so_oe released", so_oe, 0);
    for (int k = 0; k < 2; k++) begin
      frame({8'hAD, 16'h5A00 + 16'(k), 40'h0}, 3, 0);
      exp_addr = next_word(exp_addr);
      chk("R4 near top", prog_addr, exp_addr);
      chk("R9 exit", aai_active, !exp_exit(exp_addr, top_addr));
      wait_idle();
    end
    chk("R9 wel cleared", wel, 0);
    frame({8'hAD, 16'h9999, 40'h0}, 3, 0);
    chk("R9 no wrap", prog_req, 0);

    top_addr = 24'h00FFFF;
    frame({8'h80, 56'h0}, 1, 0);
    frame({8'h06, 56'h0}, 1, 0);
    frame({8'hAD, 24'h001000, 16'h4321, 16'h0}, 6, 0);
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    chk("R10 disabled so_oe", so_oe, 0);
    cs_n = 1'b1;
    wait_idle();
    frame({8'h04, 56'h0}, 1, 0);
    chk("R2 final wrdi", aai_active, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule